// File: doc/BRIEF.md
# Data Memory Lane Aligner

This block sits between the execute stage of a single-cycle core and a data memory that is one word wide and addressed by word. It forms the effective byte address of a load or store from the base register value and the signed 12-bit displacement. It turns that address into a word address and a lane index.

For stores, the block places the low byte, the low halfword or the whole source register into the lanes the address selects. It raises one write-enable bit per byte lane. For loads, it takes the word the memory returns, picks the byte or halfword at the addressed lane, and widens it to the register width. Sign or zero extension is chosen by the access code.

The whole path is combinational, so it fits inside the one cycle that the core gives each instruction. Traps for misaligned addresses belong to the core. The memory array is outside the block.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is the base value plus the 12-bit displacement sign-extended to 32 bits, with wraparound. The memory word address is that sum shifted right by two. Address bits 1:0 form the lane index.
- R2: A store with code 3'b010 (word) drives strobe 4'b1111 and puts the full source value on the write data. The lane index is ignored.
- R3: A store with code 3'b001 (halfword) drives strobe 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Address bit 0 is ignored. Source bits 15:0 appear in both halves of the write data.
- R4: A store with code 3'b000 (byte) drives a one-hot strobe with bit n set, where n is the lane index. Source bits 7:0 appear in all four byte lanes of the write data.
- R5: The strobe is 4'b0000 when the store enable is low, whatever the code. It is also 4'b0000 when the enable is high with any code other than 000, 001 or 010.
- R6: A load with code 3'b010 returns the memory word unchanged.
- R7: A load with code 3'b000 returns the byte at the lane index (lane n is bits 8n+7:8n), sign-extended to 32 bits.
- R8: A load with code 3'b100 returns the same byte zero-extended to 32 bits.
- R9: A load with code 3'b001 returns bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1, sign-extended. Address bit 0 is ignored.
- R10: A load with code 3'b101 returns the same halfword zero-extended.
- R11: A load result for codes 3'b011, 3'b110 and 3'b111 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| store_en | input | 1 | High while the current instruction is a store |
| acc_code | input | 3 | Access width and signedness code (funct3) |
| base_val | input | 32 | Base register value |
| disp | input | 12 | Signed displacement |
| src_val | input | 32 | Store source register value |
| rd_word | input | 32 | Word read from data memory |
| mem_waddr | output | 30 | Word address to data memory |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| ld_value | output | 32 | Extracted and extended load result |

## Verification
Address generation is tried with a negative displacement, the largest positive displacement and a base that wraps past the top of the address space. Together these separate correct sign extension and 32-bit wraparound from zero extension or truncation.

Each store width is applied at all four lane indices. A source value with distinct bytes shows whether the right byte or halfword was replicated. The sweep also shows that address bit 0 has no effect on halfword strobes.

Loads use a memory word whose lanes mix set and clear top bits. Every width and signedness is read at every lane, so a wrong lane choice, a wrong half or a swapped extension each gives a different value. Idle stores and unused codes show that stray strobes and stray load data are suppressed.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  // Access codes shared by loads and stores (funct3)
  localparam logic [2:0] ACC_B  = 3'b000;
  localparam logic [2:0] ACC_H  = 3'b001;
  localparam logic [2:0] ACC_W  = 3'b010;
  localparam logic [2:0] ACC_BU = 3'b100;
  localparam logic [2:0] ACC_HU = 3'b101;

  // Number of bytes touched by an access of size code sz (0,1,2)
  function automatic int acc_bytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction

  // First lane of an access: lane index aligned down to its size
  function automatic int first_lane(input int lane, input int nbytes);
    return lane & ~(nbytes - 1);
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12,
  parameter int LIDX_W = 2
) (
  input  logic [ADDR_W-1:0]        base_val,
  input  logic [OFFS_W-1:0]        disp,
  output logic [ADDR_W-LIDX_W-1:0] word_addr,
  output logic [LIDX_W-1:0]        lane_idx
);
  logic [ADDR_W-1:0] eff_addr;

  always_comb begin
    eff_addr  = base_val + {{(ADDR_W-OFFS_W){disp[OFFS_W-1]}}, disp};
    word_addr = eff_addr[ADDR_W-1:LIDX_W];
    lane_idx  = eff_addr[LIDX_W-1:0];
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  logic              store_en,
  input  logic [2:0]        acc_code,
  input  logic [LIDX_W-1:0] lane_idx,
  input  logic [DATA_W-1:0] src_val,
  output logic [LANES-1:0]  wstrb,
  output logic [DATA_W-1:0] wdata,
  output logic              st_legal
);
  int nbytes;
  int lane0;

  always_comb begin
    st_legal = store_en && (acc_code == ACC_B || acc_code == ACC_H || acc_code == ACC_W);
    nbytes   = acc_bytes(acc_code[1:0]);
    lane0    = first_lane(int'(lane_idx), nbytes);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      wstrb[i]         = st_legal && (i >= lane0) && (i < lane0 + nbytes);
      wdata[8*i +: 8]  = src_val[8*(i & (nbytes - 1)) +: 8];
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  logic [2:0]        acc_code,
  input  logic [LIDX_W-1:0] lane_idx,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ld_value
);
  logic [DATA_W-1:0] shifted;
  logic              signed_ld;
  int                lane0;

  always_comb begin
    signed_ld = !acc_code[2];
    lane0     = first_lane(int'(lane_idx), acc_bytes(acc_code[1:0]));
    shifted   = rd_word >> (8 * lane0);
    unique case (acc_code[1:0])
      2'b00:   ld_value = {{(DATA_W-8){signed_ld & shifted[7]}}, shifted[7:0]};
      2'b01:   ld_value = {{(DATA_W-16){signed_ld & shifted[15]}}, shifted[15:0]};
      2'b10:   ld_value = signed_ld ? rd_word : '0;
      default: ld_value = '0;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12,
  localparam int LANES  = DATA_W / 8,
  localparam int LIDX_W = $clog2(LANES)
) (
  input  logic                     store_en,
  input  logic [2:0]               acc_code,
  input  logic [ADDR_W-1:0]        base_val,
  input  logic [OFFS_W-1:0]        disp,
  input  logic [DATA_W-1:0]        src_val,
  input  logic [DATA_W-1:0]        rd_word,
  output logic [ADDR_W-LIDX_W-1:0] mem_waddr,
  output logic [LANES-1:0]         mem_wstrb,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [DATA_W-1:0]        ld_value
);
  logic [LIDX_W-1:0] lane_idx;
  logic              st_legal;

  lsu_agen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LIDX_W(LIDX_W)) u_agen (
    .base_val (base_val),
    .disp     (disp),
    .word_addr(mem_waddr),
    .lane_idx (lane_idx)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_store (
    .store_en(store_en),
    .acc_code(acc_code),
    .lane_idx(lane_idx),
    .src_val (src_val),
    .wstrb   (mem_wstrb),
    .wdata   (mem_wdata),
    .st_legal(st_legal)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_load (
    .acc_code(acc_code),
    .lane_idx(lane_idx),
    .rd_word (rd_word),
    .ld_value(ld_value)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LIDX_W = $clog2(LANES)
) (
  input logic              store_en,
  input logic [2:0]        acc_code,
  input logic [LIDX_W-1:0] lane_idx,
  input logic              st_legal,
  input logic [LANES-1:0]  mem_wstrb,
  input logic [DATA_W-1:0] ld_value
);
  always_comb begin
    assert_idle_no_strobe_R5: assert (store_en || mem_wstrb == '0)
      else $error("strobe raised with no store");
    assert_illegal_no_strobe_R5: assert (st_legal || mem_wstrb == '0)
      else $error("strobe raised for unsupported store code");
    assert_word_full_R2: assert (!(store_en && acc_code == ACC_W) || mem_wstrb == '1)
      else $error("word store strobe incomplete");
    assert_byte_lane_R4: assert (!(store_en && acc_code == ACC_B) ||
                                 ($onehot(mem_wstrb) && mem_wstrb[lane_idx]))
      else $error("byte store strobe not at lane");
    assert_half_pair_R3: assert (!(store_en && acc_code == ACC_H) ||
                                 ($countones(mem_wstrb) == 2 && mem_wstrb[lane_idx & ~LIDX_W'(1)]))
      else $error("halfword store strobe wrong");
    assert_byte_sext_R7: assert (acc_code != ACC_B ||
                                 ld_value[DATA_W-1:8] == {(DATA_W-8){ld_value[7]}})
      else $error("byte load not sign-extended");
    assert_byte_zext_R8: assert (acc_code != ACC_BU || ld_value[DATA_W-1:8] == '0)
      else $error("byte load not zero-extended");
    assert_half_zext_R10: assert (acc_code != ACC_HU || ld_value[DATA_W-1:16] == '0)
      else $error("halfword load not zero-extended");
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_chk (
  .store_en (store_en),
  .acc_code (acc_code),
  .lane_idx (lane_idx),
  .st_legal (st_legal),
  .mem_wstrb(mem_wstrb),
  .ld_value (ld_value)
);

// File: tb/test_lsu_lane_align.sv
`timescale 1ns/1ps
module test_lsu_lane_align;
  logic        clk = 1'b0;
  logic        store_en;
  logic [2:0]  acc_code;
  logic [31:0] base_val;
  logic [11:0] disp;
  logic [31:0] src_val;
  logic [31:0] rd_word;
  logic [29:0] mem_waddr;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic [31:0] ld_value;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .store_en(store_en), .acc_code(acc_code), .base_val(base_val), .disp(disp),
    .src_val(src_val), .rd_word(rd_word), .mem_waddr(mem_waddr),
    .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .ld_value(ld_value)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic st, input logic [2:0] code, input logic [31:0] b,
                       input logic [11:0] d, input logic [31:0] s, input logic [31:0] r);
    @(negedge clk);
    store_en = st; acc_code = code; base_val = b; disp = d; src_val = s; rd_word = r;
    #1;
  endtask

  function automatic logic [31:0] sum_addr(input logic [31:0] b, input logic [11:0] d);
    return b + 32'($signed(d));
  endfunction

  task automatic t_idle;
    for (int c = 0; c < 8; c++) begin
      apply(1'b0, 3'(c), 32'h100, 12'h3, 32'hFFFF_FFFF, 32'h0);
      check("R5 idle", {28'h0, mem_wstrb}, 32'h0);
    end
    for (int c = 3; c < 8; c++) begin
      apply(1'b1, 3'(c), 32'h100, 12'h1, 32'hFFFF_FFFF, 32'h0);
      check("R5 bad code", {28'h0, mem_wstrb}, 32'h0);
    end
  endtask

  task automatic t_agen;
    apply(1'b0, 3'b010, 32'h0000_1000, 12'hFFC, 32'h0, 32'h0);
    check("R1 negative", {2'b00, mem_waddr}, 32'h0000_03FF);
    apply(1'b0, 3'b010, 32'h0000_0001, 12'h7FF, 32'h0, 32'h0);
    check("R1 max positive", {2'b00, mem_waddr}, 32'h0000_0200);
    apply(1'b0, 3'b010, 32'hFFFF_FFFE, 12'h006, 32'h0, 32'h0);
    check("R1 wrap", {2'b00, mem_waddr}, 32'h0000_0001);
  endtask

  task automatic t_stores;
    logic [31:0] s = 32'hA1B2_C3D4;
    for (int l = 0; l < 4; l++) begin
      apply(1'b1, 3'b010, 32'h200 + 32'(l), 12'h0, s, 32'h0);
      check("R2 strobe", {28'h0, mem_wstrb}, 32'hF);
      check("R2 data", mem_wdata, s);
      apply(1'b1, 3'b001, 32'h200 + 32'(l), 12'h0, s, 32'h0);
      check("R3 strobe", {28'h0, mem_wstrb}, (l >= 2) ? 32'hC : 32'h3);
      check("R3 data", mem_wdata, 32'hC3D4_C3D4);
      apply(1'b1, 3'b000, 32'h200 + 32'(l), 12'h0, s, 32'h0);
      check("R4 strobe", {28'h0, mem_wstrb}, 32'h1 << l);
      check("R4 data", mem_wdata, 32'hD4D4_D4D4);
    end
  endtask

  task automatic t_loads;
    logic [31:0] w = 32'h80F1_7F01;
    logic [31:0] a;
    logic [7:0]  by;
    logic [15:0] hw;
    for (int l = 0; l < 4; l++) begin
      a  = sum_addr(32'h300, 12'(l));
      by = w[8*a[1:0] +: 8];
      hw = a[1] ? w[31:16] : w[15:0];
      apply(1'b0, 3'b010, 32'h300, 12'(l), 32'h0, w);
      check("R6 word", ld_value, w);
      apply(1'b0, 3'b000, 32'h300, 12'(l), 32'h0, w);
      check("R7 byte signed", ld_value, {{24{by[7]}}, by});
      apply(1'b0, 3'b100, 32'h300, 12'(l), 32'h0, w);
      check("R8 byte unsigned", ld_value, {24'h0, by});
      apply(1'b0, 3'b001, 32'h300, 12'(l), 32'h0, w);
      check("R9 half signed", ld_value, {{16{hw[15]}}, hw});
      apply(1'b0, 3'b101, 32'h300, 12'(l), 32'h0, w);
      check("R10 half unsigned", ld_value, {16'h0, hw});
    end
  endtask

  task automatic t_bad_load;
    logic [2:0] codes [3] = '{3'b011, 3'b110, 3'b111};
    foreach (codes[k]) begin
      apply(1'b0, codes[k], 32'h400, 12'h0, 32'h0, 32'hDEAD_BEEF);
      check("R11 unused code", ld_value, 32'h0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    store_en = 0; acc_code = 0; base_val = 0; disp = 0; src_val = 0; rd_word = 0;
    t_idle();
    t_agen();
    t_stores();
    t_loads();
    t_bad_load();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule